// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This peripheral guards a system against software that stops making progress. A 24-bit counter counts down once every four clock cycles. When it reaches zero, a one-cycle reset request is raised. Software restarts the countdown by writing a two-part key to the feed register: 0xAA, then 0x55 on the very next bus access. This reloads the counter from a programmable timeout constant. The live count can be read back at any time.

Enabling is a two-stage affair. Setting the enable bit does nothing on its own. The watchdog becomes armed only when a complete key sequence lands while enable is set. Enable and reset-enable can only be set; they stay set until the next system reset. Once armed, any broken key sequence raises the reset request at once. A broken sequence is a wrong second value, or any other register access between the two halves.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the mode register reads 0, the timeout constant reads 0xFF, the count reads 0xFF and `rst_req` is low.
- R2: A write to the timeout constant (word index 1) stores the written value, except that a value below 0xFF is stored as 0xFF.
- R3: A valid feed is a write of 0xAA (low 8 bits) to the feed register (word index 2), followed on the next bus access by a write of 0x55 there. After the edge that takes the second write, the count (word index 3) reads the timeout constant.
- R4: While not armed, the count never changes except by a feed. Writing enable (mode bit 0) alone does not arm the watchdog; a valid feed while enable is set arms it.
- R5: While armed, the count drops by one every 4 cycles. With reset-enable (mode bit 1) set, `rst_req` first goes high between 4*TC-3 and 4*TC cycles after the edge of the feed's second write. It stays high for exactly one cycle.
- R6: Mode bits 0 and 1 are set by writing 1 and are never cleared by a write of 0.
- R7: If armed, a write of 0xAA to feed followed by a feed write of any other value than 0x55 raises `rst_req` in the cycle after the second write's edge. If not armed, such a sequence has no effect: no reset and no reload.
- R8: If armed, any bus access to another register (or a read) between the 0xAA write and the second feed write aborts the feed and raises `rst_req` in the cycle after that access's edge.
- R9: When an armed count reaches zero, mode bit 2 (timeout flag) is set and stays set until reset. With reset-enable clear, `rst_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by bus and watchdog |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 mode, 1 timeout constant, 2 feed, 3 count |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Reads are combinational, and register writes are visible from the cycle after the write's edge. The bench therefore samples read data just before the next edge and `rst_req` one time unit after an edge. A bad or aborted feed shows on `rst_req` one cycle after the offending access. A timeout cannot be timed exactly, because the prescaler phase is free-running. The bench instead counts edges after the feed and accepts the four-cycle window that phase allows. It then confirms that the pulse is exactly one cycle wide. Timeout constants are drawn at random from a fixed seed, including values below the floor, alongside directed cases for arming, stickiness and aborted keys.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [1:0] {
    RG_MODE = 2'd0,
    RG_TMO  = 2'd1,
    RG_FEED = 2'd2,
    RG_CNT  = 2'd3
  } wdk_reg_e;
endpackage

// File: rtl/wdk_prescale.sv
module wdk_prescale #(
  parameter int PRE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == PW'(PRE_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else if (tick) phase_q <= '0;
    else phase_q <= phase_q + PW'(1);
  end

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdk_feed_seq.sv
module wdk_feed_seq #(
  parameter int          KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_A = 8'hAA,
  parameter logic [KEY_W-1:0] KEY_B = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             feed_wr,
  input  logic [KEY_W-1:0] key,
  output logic             feed_ok,
  output logic             feed_bad
);
  logic pend_q;

  assign feed_ok  = pend_q && acc && feed_wr && (key == KEY_B);
  assign feed_bad = pend_q && acc && !feed_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (acc) pend_q <= !pend_q && feed_wr && (key == KEY_A);
  end

  // R3
  key_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_ok || feed_bad) |=> !pend_q);
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int            W      = 24,
  parameter logic [W-1:0]  TC_MIN = 24'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         armed,
  input  logic         reload,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  function automatic logic [W-1:0] step(input logic [W-1:0] c,
                                        input logic t, input logic a);
    if (a && t && (c != '0)) return c - W'(1);
    return c;
  endfunction

  assign expire = armed && tick && !reload && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= TC_MIN;
    else if (reload) cnt <= load_val;
    else cnt <= step(cnt, tick, armed);
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !reload) |=> $stable(cnt));
  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !reload) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) - W'(1))));
  // R3
  reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == $past(load_val)));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int              CNT_W   = 24,
  parameter int              PRE_DIV = 4,
  parameter logic [CNT_W-1:0] TC_MIN = 24'hFF,
  parameter int              KEY_W   = 8,
  parameter logic [KEY_W-1:0] KEY_A  = 8'hAA,
  parameter logic [KEY_W-1:0] KEY_B  = 8'h55
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             rst_req
);
  import wdk_pkg::*;

  localparam int MODE_PAD = CNT_W - 3;

  function automatic logic [CNT_W-1:0] clamp_tc(input logic [CNT_W-1:0] v);
    return (v < TC_MIN) ? TC_MIN : v;
  endfunction

  logic en_q, rsten_q, tmo_q, armed_q, rst_q;
  logic [CNT_W-1:0] tc_q, cnt;
  logic tick, feed_ok, feed_bad, expire;
  logic wr_mode, wr_tc, feed_wr;

  assign wr_mode = bus_sel && bus_wr && (bus_addr == RG_MODE);
  assign wr_tc   = bus_sel && bus_wr && (bus_addr == RG_TMO);
  assign feed_wr = bus_wr && (bus_addr == RG_FEED);

  wdk_prescale #(.PRE_DIV(PRE_DIV)) i_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  wdk_feed_seq #(.KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) i_feed (
    .clk(clk), .rst_n(rst_n), .acc(bus_sel), .feed_wr(feed_wr),
    .key(bus_wdata[KEY_W-1:0]), .feed_ok(feed_ok), .feed_bad(feed_bad));

  wdk_count #(.W(CNT_W), .TC_MIN(TC_MIN)) i_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .armed(armed_q),
    .reload(feed_ok), .load_val(tc_q), .cnt(cnt), .expire(expire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
      tmo_q   <= 1'b0;
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
      tc_q    <= TC_MIN;
    end else begin
      if (wr_mode) begin
        en_q    <= en_q | bus_wdata[0];
        rsten_q <= rsten_q | bus_wdata[1];
      end
      if (wr_tc) tc_q <= clamp_tc(bus_wdata);
      armed_q <= armed_q | (feed_ok && en_q);
      tmo_q   <= tmo_q | expire;
      rst_q   <= (expire && rsten_q) || (feed_bad && armed_q);
    end
  end

  always_comb begin
    case (bus_addr)
      RG_MODE: bus_rdata = {{MODE_PAD{1'b0}}, tmo_q, rsten_q, en_q};
      RG_TMO:  bus_rdata = tc_q;
      RG_CNT:  bus_rdata = cnt;
      default: bus_rdata = '0;
    endcase
  end

  assign rst_req = rst_q;

  // R6
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && rsten_q) |=> (en_q && rsten_q));
  // R6
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  // R9
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> tmo_q);
  // R7
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !rst_req);
  // R2
  tc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q >= TC_MIN);
  // R4
  arm_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !en_q) |=> !armed_q);
endmodule

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [23:0] bus_wdata = '0;
  logic [23:0] bus_rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdog_keyed i_wdog_keyed (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req));

  function automatic int exp_tc(input int v);
    return (v < 255) ? 255 : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = 24'(d);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = int'(bus_rdata);
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 'hAA);
    wr(2'd2, 'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v, v2, hit, ones;
    void'($urandom(32'd4242));

    // R1 reset state
    do_reset();
    rd(2'd0, v); check(v == 0, "R1 mode", v, 0);
    rd(2'd1, v); check(v == 'hFF, "R1 tc", v, 'hFF);
    rd(2'd3, v); check(v == 'hFF, "R1 count", v, 'hFF);
    check(rst_req == 1'b0, "R1 rst_req", int'(rst_req), 0);

    // R2 clamp and plain store
    wr(2'd1, 'h10);  rd(2'd1, v); check(v == 'hFF, "R2 clamp", v, 'hFF);
    wr(2'd1, 'h100); rd(2'd1, v); check(v == 'h100, "R2 store", v, 'h100);

    // R3 unarmed feed reloads
    wr(2'd1, 'h300); feed();
    rd(2'd3, v); check(v == 'h300, "R3 reload", v, 'h300);
    // R4 unarmed count holds
    repeat (20) @(posedge clk);
    rd(2'd3, v); check(v == 'h300, "R4 hold unarmed", v, 'h300);

    // R7 unarmed bad key: no reset, no reload
    wr(2'd1, 'h200);
    wr(2'd2, 'hAA); wr(2'd2, 'h12);
    check(rst_req == 1'b0, "R7 unarmed bad", int'(rst_req), 0);
    rd(2'd3, v); check(v == 'h300, "R7 no reload", v, 'h300);

    // R4 enable alone does not arm
    wr(2'd0, 1);
    repeat (40) @(posedge clk);
    rd(2'd3, v); check(v == 'h300, "R4 enable only", v, 'h300);
    feed();
    rd(2'd3, v); check(v == 'h200, "R3 reload armed", v, 'h200);
    repeat (40) @(posedge clk);
    rd(2'd3, v);
    check(v < 'h200 && v >= 'h200 - 12, "R4 counts after arm", v, 'h200 - 10);

    // R6 sticky mode bits
    wr(2'd0, 0); rd(2'd0, v); check((v & 3) == 1, "R6 en sticky", v, 1);
    wr(2'd0, 2); wr(2'd0, 0); rd(2'd0, v); check((v & 3) == 3, "R6 both sticky", v, 3);

    // R7 armed bad key
    wr(2'd2, 'hAA); wr(2'd2, 'h56);
    check(rst_req == 1'b1, "R7 armed bad", int'(rst_req), 1);
    @(posedge clk); #1;
    check(rst_req == 1'b0, "R7 one cycle", int'(rst_req), 0);

    // R8 abort by another access
    do_reset();
    wr(2'd0, 3); feed();
    wr(2'd2, 'hAA); rd(2'd1, v);
    check(rst_req == 1'b1, "R8 abort", int'(rst_req), 1);
    @(posedge clk); #1;
    check(rst_req == 1'b0, "R8 one cycle", int'(rst_req), 0);

    // R9 timeout flag without reset action
    do_reset();
    wr(2'd1, 'h100); wr(2'd0, 1); feed();
    ones = 0;
    for (int i = 0; i < 4 * 'h100 + 12; i++) begin
      @(posedge clk); #1;
      if (rst_req) ones++;
    end
    check(ones == 0, "R9 no rst_req", ones, 0);
    rd(2'd0, v); check((v & 4) == 4, "R9 flag set", v, 5);
    rd(2'd3, v); check(v == 0, "R9 count at zero", v, 0);

    // R5 random timeouts
    for (int it = 0; it < 10; it++) begin
      v2 = int'($urandom_range(0, 700));
      do_reset();
      wr(2'd1, v2);
      rd(2'd1, v); check(v == exp_tc(v2), "R2 random clamp", v, exp_tc(v2));
      wr(2'd0, 3); feed();
      hit = 0; ones = 0;
      for (int n = 1; n <= 4 * exp_tc(v2) + 8; n++) begin
        @(posedge clk); #1;
        if (rst_req) begin
          ones++;
          if (hit == 0) hit = n;
        end
      end
      check(hit >= 4 * exp_tc(v2) - 3 && hit <= 4 * exp_tc(v2), "R5 timeout window",
            hit, 4 * exp_tc(v2));
      check(ones == 1, "R5 pulse width", ones, 1);
      rd(2'd0, v); check((v & 4) == 4, "R9 flag after reset pulse", v, 7);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule